// File: doc/BRIEF.md
# Zero-Crossing Gated Wiper Register

This block holds the 5-bit tap position of one channel of a stepped audio attenuator. It decodes the position into a one-hot select for 32 tap switches and reports the attenuation of the selected tap in whole dB. Software-side logic changes the position with a direct load or with single up/down steps. Steps saturate at both ends.

With deferral enabled, a requested change does not reach the tap select right away. It is parked as a pending target and applied at the next one-cycle strobe from an external zero-crossing detector, so that the switch change does not produce a click. Later requests overwrite the pending target; steps apply to that target. A wait limit bounds how long a parked change can sit. When the limit expires, the change is applied anyway and a one-cycle flag marks the update as forced. With deferral disabled, a change applies on the next clock edge.

Top module: `zc_wiper_reg`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit's index equals `position`.
- R2: While reset is asserted and after it is released, `position` is 0 (mute), `tap_sel` is 32'h1, `atten_db` is -92, and `pending` and `forced` are 0.
- R3: With `defer_en`=0, a cycle with `load_valid`=1 makes `position` equal `load_value` after the next clock edge. A load takes priority over any step request in the same cycle.
- R4: A step with `step_up`=1 and `step_down`=0 adds one, saturating at 31. A step with `step_down`=1 and `step_up`=0 subtracts one, saturating at 0. Both asserted together is not a request and changes nothing.
- R5: With `defer_en`=1, a request leaves `position` unchanged and sets `pending`. The target is applied at the edge of the next cycle where `zc_strobe`=1. A request in a cycle that carries `zc_strobe` is applied at once.
- R6: While a change is pending, each new load replaces the target, and each step moves the pending target (not `position`). One strobe commits only the latest target.
- R7: If no strobe arrives, the pending target is committed exactly WAIT_LIMIT clock edges after the edge that set `pending`. `forced` is 1 for the one cycle after that commit and 0 otherwise.
- R8: `atten_db` (8-bit two's complement, dB) is n-31 for taps 20..31, 2n-51 for 10..19, 3n-61 for 5..9, 4n-66 for 1..4, and -92 for tap 0.
- R9: Clearing `defer_en` while a change is pending commits it at the next edge without setting `forced`. A `zc_strobe` with nothing pending and no request has no effect on `position`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| defer_en | input | 1 | 1: hold changes until a zero-crossing strobe |
| load_valid | input | 1 | Load `load_value` as the new target |
| load_value | input | 5 | Tap to load |
| step_up | input | 1 | Move target one tap up |
| step_down | input | 1 | Move target one tap down |
| zc_strobe | input | 1 | One-cycle zero-crossing event |
| position | output | 5 | Current applied tap |
| tap_sel | output | 32 | One-hot tap switch select |
| atten_db | output | 8 | Attenuation of current tap, signed dB |
| pending | output | 1 | A deferred change is waiting |
| forced | output | 1 | Last commit came from the wait limit |

## Verification
The bench builds the block with WAIT_LIMIT set to 8 instead of the default 1000. The forced-commit path therefore expires within a few cycles, and the exact expiry edge can be checked next to the strobe-driven commit. All 32 taps are loaded directly, so the full dB curve and the one-hot decode are compared against a model of the formula. Saturation, overwrite of a pending target and the deferral toggle are each driven through their own short sequences.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
  localparam int TAP_BITS = 5;
  localparam int TAP_COUNT = 1 << TAP_BITS;
  localparam int DB_BITS = 8;
  localparam int MUTE_DB = -92;

  typedef logic [TAP_BITS-1:0] tap_t;
  typedef logic [TAP_COUNT-1:0] sel_t;
  typedef logic signed [DB_BITS-1:0] db_t;

  // Piecewise log curve, steepest segments near the bottom of the range.
  function automatic db_t tap_to_db(input tap_t n);
    int v;
    int t;
    t = int'(n);
    if (t == 0)       v = MUTE_DB;
    else if (t >= 20) v = t - 31;
    else if (t >= 10) v = 2 * t - 51;
    else if (t >= 5)  v = 3 * t - 61;
    else              v = 4 * t - 66;
    return db_t'(v);
  endfunction
endpackage

// File: rtl/zcw_target.sv
module zcw_target
  import zcw_pkg::*;
(
  input  tap_t base,
  input  logic load_valid,
  input  tap_t load_value,
  input  logic step_up,
  input  logic step_down,
  output logic has_req,
  output tap_t target
);
  localparam tap_t TAP_MAX = tap_t'(TAP_COUNT - 1);

  logic inc_only;
  logic dec_only;

  assign inc_only = step_up & ~step_down;
  assign dec_only = step_down & ~step_up;
  assign has_req  = load_valid | inc_only | dec_only;

  always_comb begin
    target = base;
    if (load_valid) begin
      target = load_value;
    end else if (inc_only) begin
      if (base != TAP_MAX) target = base + tap_t'(1);
    end else if (dec_only) begin
      if (base != '0) target = base - tap_t'(1);
    end
  end
endmodule

// File: rtl/zcw_hold_timer.sv
module zcw_hold_timer #(
  parameter int unsigned WAIT_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic commit,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired = pending & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!pending || commit) cnt_d = '0;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/zcw_tap_decode.sv
module zcw_tap_decode
  import zcw_pkg::*;
(
  input  tap_t pos,
  output sel_t sel,
  output db_t  db
);
  for (genvar i = 0; i < TAP_COUNT; i++) begin : g_sw
    assign sel[i] = (pos == tap_t'(i));
  end

  assign db = tap_to_db(pos);
endmodule

// File: rtl/zc_wiper_reg.sv
module zc_wiper_reg
  import zcw_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        defer_en,
  input  logic        load_valid,
  input  logic [4:0]  load_value,
  input  logic        step_up,
  input  logic        step_down,
  input  logic        zc_strobe,
  output logic [4:0]  position,
  output logic [31:0] tap_sel,
  output logic [7:0]  atten_db,
  output logic        pending,
  output logic        forced
);
  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  tap_t pos_q, pos_d;
  tap_t hold_q, hold_d;
  logic pend_q, pend_d;
  logic frc_q, frc_d;

  tap_t base;
  tap_t req_target;
  tap_t cand;
  logic has_req;
  logic has_work;
  logic expired;
  logic commit;
  db_t  db_w;

  assign base = pend_q ? hold_q : pos_q;

  zcw_target u_target (
    .base       (base),
    .load_valid (load_valid),
    .load_value (load_value),
    .step_up    (step_up),
    .step_down  (step_down),
    .has_req    (has_req),
    .target     (req_target)
  );

  zcw_hold_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pending (pend_q),
    .commit  (commit),
    .expired (expired)
  );

  assign cand     = has_req ? req_target : hold_q;
  assign has_work = has_req | pend_q;
  assign commit   = has_work & (~defer_en | zc_strobe | expired);

  always_comb begin
    pos_d  = pos_q;
    hold_d = hold_q;
    pend_d = pend_q;
    frc_d  = 1'b0;
    if (commit) begin
      pos_d  = cand;
      pend_d = 1'b0;
      frc_d  = expired & defer_en & ~zc_strobe;
    end else if (has_work) begin
      hold_d = cand;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pos_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      frc_q  <= frc_d;
    end
  end

  zcw_tap_decode u_decode (
    .pos (pos_q),
    .sel (tap_sel),
    .db  (db_w)
  );

  assign position = pos_q;
  assign atten_db = db_w;
  assign pending  = pend_q;
  assign forced   = frc_q;
endmodule

// File: rtl/zc_wiper_reg_chk.sv
module zc_wiper_reg_chk #(
  parameter int unsigned WAIT_LIMIT = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        defer_en,
  input logic        load_valid,
  input logic        step_up,
  input logic        step_down,
  input logic        zc_strobe,
  input logic [4:0]  position,
  input logic [31:0] tap_sel,
  input logic [7:0]  atten_db,
  input logic        pending,
  input logic        forced
);
  localparam int CW = $clog2(WAIT_LIMIT + 2);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_cnt <= '0;
    else if (pending) wait_cnt <= wait_cnt + CW'(1);
    else              wait_cnt <= '0;
  end

  // R1
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[position]);

  // R8
  mute_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (position == 5'd0) |-> (atten_db == 8'hA4));

  // R4
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_down && !load_valid && !defer_en && !pending && position == 5'd31)
    |=> (position == 5'd31));

  // R5
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_en && !zc_strobe && !pending) |=> (position == $past(position)));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (wait_cnt < CW'(WAIT_LIMIT)));

  // R7
  forced_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> ($past(pending) && $past(defer_en) && !$past(zc_strobe)));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !load_valid && (step_up == step_down)) |=> $stable(position));
endmodule

bind zc_wiper_reg zc_wiper_reg_chk #(.WAIT_LIMIT(WAIT_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .defer_en   (defer_en),
  .load_valid (load_valid),
  .step_up    (step_up),
  .step_down  (step_down),
  .zc_strobe  (zc_strobe),
  .position   (position),
  .tap_sel    (tap_sel),
  .atten_db   (atten_db),
  .pending    (pending),
  .forced     (forced)
);

// File: tb/test_zc_wiper_reg.sv
`timescale 1ns/1ps
module test_zc_wiper_reg;
  localparam int unsigned LIMIT = 8;

  typedef struct {
    string      tag;
    logic [4:0] pos;
    logic       pend;
    logic       frc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        defer_en = 1'b0;
  logic        load_valid = 1'b0;
  logic [4:0]  load_value = '0;
  logic        step_up = 1'b0;
  logic        step_down = 1'b0;
  logic        zc_strobe = 1'b0;
  logic [4:0]  position;
  logic [31:0] tap_sel;
  logic [7:0]  atten_db;
  logic        pending;
  logic        forced;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  zc_wiper_reg #(.WAIT_LIMIT(LIMIT)) i_zc_wiper_reg (
    .clk, .rst_n, .defer_en, .load_valid, .load_value, .step_up,
    .step_down, .zc_strobe, .position, .tap_sel, .atten_db, .pending, .forced
  );

  function automatic logic [7:0] model_db(input logic [4:0] p);
    int n;
    n = int'(p);
    case (1'b1)
      (n == 0): return 8'(-92);
      (n < 5):  return 8'(4 * n - 66);
      (n < 10): return 8'(3 * n - 61);
      (n < 20): return 8'(2 * n - 51);
      default:  return 8'(n - 31);
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      exp_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      cmp(it.tag, "position", 32'(position), 32'(it.pos));
      cmp(it.tag, "tap_sel R1", tap_sel, 32'h1 << it.pos);
      cmp(it.tag, "atten_db R8", 32'(atten_db), 32'(model_db(it.pos)));
      cmp(it.tag, "pending", 32'(pending), 32'(it.pend));
      cmp(it.tag, "forced", 32'(forced), 32'(it.frc));
    end
  end

  task automatic expect_out(string tag, logic [4:0] p, logic pd, logic f);
    exp_t it;
    it.tag = tag; it.pos = p; it.pend = pd; it.frc = f;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  // Driver: one clock of stimulus, then the result is sampled at the next negedge.
  task automatic cyc(logic ld, logic [4:0] v, logic up, logic dn, logic zc);
    load_valid = ld; load_value = v; step_up = up; step_down = dn; zc_strobe = zc;
    @(negedge clk);
    load_valid = 1'b0; step_up = 1'b0; step_down = 1'b0; zc_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    expect_out("R2 in reset", 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R2 after release", 5'd0, 1'b0, 1'b0);

    // R3 / R8: every tap by direct load
    for (int n = 0; n < 32; n++) begin
      cyc(1'b1, 5'(n), 1'b0, 1'b0, 1'b0);
      expect_out("R3 R8 direct load", 5'(n), 1'b0, 1'b0);
    end

    // R4 saturation and conflicting steps
    cyc(1'b1, 5'd31, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    expect_out("R4 up saturate", 5'd31, 1'b0, 1'b0);
    cyc(1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 down saturate", 5'd0, 1'b0, 1'b0);
    cyc(1'b1, 5'd12, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    expect_out("R4 up", 5'd13, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 down", 5'd12, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b1, 1'b1, 1'b0);
    expect_out("R4 both ignored", 5'd12, 1'b0, 1'b0);
    cyc(1'b1, 5'd20, 1'b1, 1'b0, 1'b0);
    expect_out("R3 load beats step", 5'd20, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    expect_out("R9 idle strobe", 5'd20, 1'b0, 1'b0);

    // R5 deferral
    defer_en = 1'b1;
    cyc(1'b1, 5'd10, 1'b0, 1'b0, 1'b0);
    expect_out("R5 held", 5'd20, 1'b1, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    expect_out("R5 still held", 5'd20, 1'b1, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    expect_out("R5 strobe commit", 5'd10, 1'b0, 1'b0);
    cyc(1'b1, 5'd25, 1'b0, 1'b0, 1'b1);
    expect_out("R5 request with strobe", 5'd25, 1'b0, 1'b0);

    // R6 latest target wins
    cyc(1'b1, 5'd5, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 step on pending", 5'd25, 1'b1, 1'b0);
    cyc(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    expect_out("R6 latest committed", 5'd19, 1'b0, 1'b0);
    cyc(1'b1, 5'd31, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b1);
    expect_out("R6 R4 pending saturate", 5'd31, 1'b0, 1'b0);

    // R7 forced commit after LIMIT edges
    cyc(1'b1, 5'd7, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < int'(LIMIT) - 1; k++) cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    expect_out("R7 before limit", 5'd31, 1'b1, 1'b0);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    expect_out("R7 forced commit", 5'd7, 1'b0, 1'b1);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    expect_out("R7 forced pulse ends", 5'd7, 1'b0, 1'b0);

    // R9 deferral dropped while pending
    cyc(1'b1, 5'd3, 1'b0, 1'b0, 1'b0);
    expect_out("R9 pending", 5'd7, 1'b1, 1'b0);
    defer_en = 1'b0;
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    expect_out("R9 commit on disable", 5'd3, 1'b0, 1'b0);

    summary();
  end
endmodule